// File: doc/BRIEF.md
# Single-Character Command Controller for a Capture Engine

This block sits between a byte-stream host link and a sample capture engine. Each incoming byte is one printable ASCII command. The controller turns the start, stop and clear commands into one-cycle pulses for the capture engine. It answers a status query with a single status letter and an identify query with a short fixed string. On a dump command it walks the stored 32-bit records from address 0 up to the last written record. It reads each record through a one-cycle-latency read port and streams it out, either as raw bytes or as uppercase hexadecimal text. Lower-case `d` selects the raw form and upper-case `D` selects the text form.

Both byte streams use valid/ready. An input byte is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for as long as a reply or dump is being sent, so the host cannot push a new command during that time. An output byte is taken on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the controller keeps `out_valid` and `out_data` unchanged, so the receiver may stall for any number of cycles. The capture engine and the record memory lie outside the block. Their status and record count arrive on plain input pins.

Top module: `ascii_cmd_ctrl`

## Requirements
- R1: An accepted `g` (0x67) while `mem_full` is low gives a `cap_start` pulse that is high for exactly one cycle, in the cycle after acceptance.
- R2: An accepted `g` while `mem_full` is high produces no `cap_start` pulse. Only a clear command, followed by the memory no longer being full, lets a later start through.
- R3: An accepted `s` (0x73) gives a one-cycle `cap_stop` pulse and an accepted `r` (0x72) gives a one-cycle `cap_clear` pulse, each in the cycle after acceptance. At most one of the three control pulses is high in any cycle.
- R4: An accepted `S` (0x53) sends one byte. The byte is `f` (0x66) if `mem_full` is high, otherwise `r` (0x72) if `cap_running` is high, otherwise `s` (0x73). Both inputs are sampled when the command is accepted.
- R5: An accepted `i` (0x69) sends the four bytes 0x4C 0x41 0x38 0x0A ("LA8" and a line feed), in that order.
- R6: An accepted `d` (0x64) takes a snapshot of `rec_count` and sends each record from address 0 to `rec_count`-1 as four bytes, most significant byte first. If `rec_count` is 0, nothing is sent.
- R7: An accepted `D` (0x44) sends each record as eight uppercase hex characters, most significant nibble first, followed by 0x0A.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: `cmd_ready` is low whenever a reply or dump is being sent. It is high at all other times.
- R10: Any other byte is accepted and has no effect: no output byte and no control pulse.
- R11: After reset, `out_valid`, `mem_rd_en` and all control pulses are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_data | input | 8 | Command byte |
| out_valid | output | 1 | Reply byte offered |
| out_ready | input | 1 | Receiver takes the reply byte |
| out_data | output | 8 | Reply byte |
| cap_start | output | 1 | One-cycle start pulse to the capture engine |
| cap_stop | output | 1 | One-cycle stop pulse to the capture engine |
| cap_clear | output | 1 | One-cycle clear pulse to the capture engine |
| cap_running | input | 1 | Capture engine is sampling |
| mem_full | input | 1 | Record memory is full |
| rec_count | input | ADDR_W+1 | Number of records stored |
| mem_rd_en | output | 1 | Record read strobe |
| mem_rd_addr | output | ADDR_W | Record read address |
| mem_rd_data | input | 32 | Record data, valid one cycle after the strobe |

## Verification
The bench sends a start command while the memory is full. A design that ignored the full flag would pulse `cap_start` there. It queries status with full and running both high, which catches a design that gives running the higher priority. It also holds off the receiver in the middle of a text dump; a design that moved on regardless would drop or change a character. Finally, it dumps with a record count of zero and sends unknown bytes. A design that sent one record anyway, or treated unknown bytes as commands, would produce stray output or pulses.

// File: rtl/cmdc_pkg.sv
package cmdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT, ST_ID, ST_FETCH, ST_WAIT, ST_SEND
  } cmdc_state_e;

  typedef enum logic [2:0] {
    K_NONE, K_GO, K_HALT, K_CLEAR, K_STATUS, K_IDENT, K_DUMP_RAW, K_DUMP_HEX
  } cmdc_kind_e;

  localparam int REC_BYTES = 4;
  localparam int REC_NIBS  = 2 * REC_BYTES;
  localparam int ID_LEN    = 4;
  localparam logic [7:0] CH_LF = 8'h0A;

  function automatic logic [7:0] id_char(input logic [1:0] i);
    case (i)
      2'd0:    return 8'h4C;
      2'd1:    return 8'h41;
      2'd2:    return 8'h38;
      default: return CH_LF;
    endcase
  endfunction

endpackage

// File: rtl/cmdc_decode.sv
module cmdc_decode
  import cmdc_pkg::*;
(
  input  logic [7:0] byte_in,
  output cmdc_kind_e kind
);
  always_comb begin
    case (byte_in)
      8'h67:   kind = K_GO;
      8'h73:   kind = K_HALT;
      8'h72:   kind = K_CLEAR;
      8'h53:   kind = K_STATUS;
      8'h69:   kind = K_IDENT;
      8'h64:   kind = K_DUMP_RAW;
      8'h44:   kind = K_DUMP_HEX;
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/cmdc_status_sel.sv
module cmdc_status_sel (
  input  logic       full,
  input  logic       running,
  output logic [7:0] code
);
  always_comb begin
    if (full)         code = 8'h66;
    else if (running) code = 8'h72;
    else              code = 8'h73;
  end
endmodule

// File: rtl/cmdc_hex_char.sv
module cmdc_hex_char (
  input  logic [3:0] nib,
  output logic [7:0] ch
);
  always_comb begin
    if (nib < 4'd10) ch = 8'h30 + {4'd0, nib};
    else             ch = 8'h37 + {4'd0, nib};
  end
endmodule

// File: rtl/ascii_cmd_ctrl.sv
module ascii_cmd_ctrl
  import cmdc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              cap_start,
  output logic              cap_stop,
  output logic              cap_clear,
  input  logic              cap_running,
  input  logic              mem_full,
  input  logic [ADDR_W:0]   rec_count,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data
);
  localparam int CNT_W = ADDR_W + 1;

  cmdc_state_e        state;
  cmdc_kind_e         kind;
  logic [7:0]         stat_now, stat_q, hex_ch;
  logic [3:0]         idx, last_idx;
  logic [ADDR_W-1:0]  rd_addr;
  logic [CNT_W-1:0]   cnt_q, next_cnt;
  logic [31:0]        rec;
  logic               hex_mode;
  logic [3:0]         nib;
  logic               take;

  cmdc_decode     u_dec (.byte_in(cmd_data), .kind(kind));
  cmdc_status_sel u_sel (.full(mem_full), .running(cap_running), .code(stat_now));
  cmdc_hex_char   u_hex (.nib(nib), .ch(hex_ch));

  assign cmd_ready   = (state == ST_IDLE);
  assign mem_rd_en   = (state == ST_FETCH);
  assign mem_rd_addr = rd_addr;
  assign out_valid   = (state == ST_STAT) || (state == ST_ID) || (state == ST_SEND);
  assign take        = out_valid && out_ready;
  assign last_idx    = hex_mode ? 4'(REC_NIBS) : 4'(REC_BYTES - 1);
  assign next_cnt    = {1'b0, rd_addr} + CNT_W'(1);
  assign nib         = rec[{3'd7 - idx[2:0], 2'b00} +: 4];

  always_comb begin
    case (state)
      ST_STAT: out_data = stat_q;
      ST_ID:   out_data = id_char(idx[1:0]);
      ST_SEND: begin
        if (!hex_mode)              out_data = rec[{2'd3 - idx[1:0], 3'b000} +: 8];
        else if (idx == last_idx)   out_data = CH_LF;
        else                        out_data = hex_ch;
      end
      default: out_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cap_start <= 1'b0;
      cap_stop  <= 1'b0;
      cap_clear <= 1'b0;
      stat_q    <= 8'h00;
      idx       <= 4'd0;
      rd_addr   <= '0;
      cnt_q     <= '0;
      rec       <= 32'h0;
      hex_mode  <= 1'b0;
    end else begin
      cap_start <= 1'b0;
      cap_stop  <= 1'b0;
      cap_clear <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          case (kind)
            K_GO:     cap_start <= !mem_full;
            K_HALT:   cap_stop  <= 1'b1;
            K_CLEAR:  cap_clear <= 1'b1;
            K_STATUS: begin stat_q <= stat_now; state <= ST_STAT; end
            K_IDENT:  begin idx <= 4'd0; state <= ST_ID; end
            K_DUMP_RAW, K_DUMP_HEX: begin
              hex_mode <= (kind == K_DUMP_HEX);
              if (rec_count != '0) begin
                cnt_q   <= rec_count;
                rd_addr <= '0;
                idx     <= 4'd0;
                state   <= ST_FETCH;
              end
            end
            default: ;
          endcase
        end
        ST_STAT: if (out_ready) state <= ST_IDLE;
        ST_ID: if (out_ready) begin
          if (idx == 4'(ID_LEN - 1)) begin
            idx   <= 4'd0;
            state <= ST_IDLE;
          end else begin
            idx <= idx + 4'd1;
          end
        end
        ST_FETCH: state <= ST_WAIT;
        ST_WAIT: begin
          rec   <= mem_rd_data;
          idx   <= 4'd0;
          state <= ST_SEND;
        end
        ST_SEND: if (take) begin
          if (idx == last_idx) begin
            idx <= 4'd0;
            if (next_cnt == cnt_q) begin
              state <= ST_IDLE;
            end else begin
              rd_addr <= rd_addr + ADDR_W'(1);
              state   <= ST_FETCH;
            end
          end else begin
            idx <= idx + 4'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdc_chk.sv
module cmdc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       cap_start,
  input logic       cap_stop,
  input logic       cap_clear,
  input logic       mem_full,
  input logic       mem_rd_en
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  a_r1_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_data == 8'h67 && !mem_full) |=> cap_start);

  a_r2_full_blocks_go: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_data == 8'h67 && mem_full) |=> !cap_start);

  a_r3_halt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_data == 8'h73) |=> cap_stop);

  a_r3_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_start, cap_stop, cap_clear}));

  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r9_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || mem_rd_en) |-> !cmd_ready);
endmodule

bind ascii_cmd_ctrl cmdc_chk u_chk (.*);

// File: tb/sim_ascii_cmd_ctrl.sv
module sim_ascii_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic cmd_ready, out_valid, cap_start, cap_stop, cap_clear, mem_rd_en;
  logic [7:0] out_data;
  logic cap_running = 1'b0, mem_full = 1'b0;
  logic [AW:0] rec_count = '0;
  logic [AW-1:0] mem_rd_addr;
  logic [31:0] mem_rd_data = 32'h0;
  logic [31:0] mem [0:(1<<AW)-1];
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ascii_cmd_ctrl #(.ADDR_W(AW)) u0 (.*);

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  function automatic logic [31:0] rec_val(input int a);
    return 32'hA5C3_0F91 + 32'(a) * 32'h0103_0507;
  endfunction

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'd0, n}) : (8'h41 + {4'd0, n} - 8'd10);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic recv(input string req, output logic [7:0] b);
    int n = 0;
    while (!out_valid && n < 50) begin @(negedge clk); n++; end
    if (!out_valid) begin
      nchk++; nfail++;
      $display("FAIL %s no byte: actual out_valid 0 expected 1", req);
      b = 8'hxx;
    end else begin
      b = out_data;
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  task automatic expect_silence(input string req, input int cycles);
    logic seen = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (out_valid || cap_start || cap_stop || cap_clear) seen = 1'b1;
    end
    chk(req, "silent output and pulses", {31'd0, seen}, 32'd0);
    chk(req, "cmd_ready idle", {31'd0, cmd_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R11", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R11", "cmd_ready", {31'd0, cmd_ready}, 32'd1);
    chk("R11", "pulses", {29'd0, cap_start, cap_stop, cap_clear}, 32'd0);
    chk("R11", "mem_rd_en", {31'd0, mem_rd_en}, 32'd0);
  endtask

  task automatic t_go;
    mem_full = 1'b0;
    send_cmd(8'h67);
    chk("R1", "cap_start after g", {31'd0, cap_start}, 32'd1);
    @(negedge clk);
    chk("R1", "cap_start one cycle", {31'd0, cap_start}, 32'd0);
    mem_full = 1'b1;
    send_cmd(8'h67);
    chk("R2", "cap_start while full", {31'd0, cap_start}, 32'd0);
    @(negedge clk);
    chk("R2", "cap_start while full later", {31'd0, cap_start}, 32'd0);
    mem_full = 1'b0;
  endtask

  task automatic t_halt_clear;
    send_cmd(8'h73);
    chk("R3", "cap_stop after s", {29'd0, cap_start, cap_stop, cap_clear}, 32'd2);
    @(negedge clk);
    chk("R3", "cap_stop one cycle", {31'd0, cap_stop}, 32'd0);
    send_cmd(8'h72);
    chk("R3", "cap_clear after r", {29'd0, cap_start, cap_stop, cap_clear}, 32'd1);
  endtask

  task automatic t_status;
    logic [7:0] b;
    mem_full = 1'b1; cap_running = 1'b1;
    send_cmd(8'h53);
    recv("R4", b);
    chk("R4", "full beats running", {24'd0, b}, 32'h66);
    mem_full = 1'b0;
    send_cmd(8'h53);
    recv("R4", b);
    chk("R4", "running", {24'd0, b}, 32'h72);
    cap_running = 1'b0;
    send_cmd(8'h53);
    recv("R4", b);
    chk("R4", "stopped", {24'd0, b}, 32'h73);
  endtask

  task automatic t_ident;
    logic [7:0] b;
    logic [7:0] exp [4] = '{8'h4C, 8'h41, 8'h38, 8'h0A};
    send_cmd(8'h69);
    chk("R9", "cmd_ready low while replying", {31'd0, cmd_ready}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      recv("R5", b);
      chk("R5", "identify byte", {24'd0, b}, {24'd0, exp[k]});
    end
    expect_silence("R5", 3);
  endtask

  task automatic t_dump_raw;
    logic [7:0] b;
    rec_count = 9'd3;
    send_cmd(8'h64);
    chk("R9", "cmd_ready low while dumping", {31'd0, cmd_ready}, 32'd0);
    for (int a = 0; a < 3; a++) begin
      for (int k = 0; k < 4; k++) begin
        recv("R6", b);
        chk("R6", "raw byte", {24'd0, b}, {24'd0, rec_val(a)[31-8*k -: 8]});
      end
    end
    expect_silence("R6", 6);
  endtask

  task automatic t_dump_hex;
    logic [7:0] b;
    logic [7:0] first;
    rec_count = 9'd2;
    send_cmd(8'h44);
    while (!out_valid) @(negedge clk);
    first = out_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8", "held valid under stall", {31'd0, out_valid}, 32'd1);
      chk("R8", "held data under stall", {24'd0, out_data}, {24'd0, first});
    end
    for (int a = 0; a < 2; a++) begin
      for (int k = 0; k < 8; k++) begin
        recv("R7", b);
        chk("R7", "hex char", {24'd0, b}, {24'd0, hexc(rec_val(a)[31-4*k -: 4])});
      end
      recv("R7", b);
      chk("R7", "line feed", {24'd0, b}, 32'h0A);
    end
    expect_silence("R7", 6);
  endtask

  task automatic t_ignored;
    send_cmd(8'h78);
    expect_silence("R10", 5);
    send_cmd(8'h00);
    expect_silence("R10", 5);
    rec_count = '0;
    send_cmd(8'h64);
    expect_silence("R6", 6);
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) mem[a] = rec_val(a);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_go();
    t_halt_clear();
    t_status();
    t_ident();
    t_dump_raw();
    t_dump_hex();
    t_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule